// File: doc/BRIEF.md
# Reserved Load and Conditional Store Unit

This block runs the reservation pair of a 64-bit atomic extension for a single hardware thread. It takes one instruction word with its two source operands, decodes it, and does one of three things. It issues a reserved read to a request/response memory port. It issues a conditional write to the same port. Or it completes at once with a fault or a failure code. Its result is a single destination value with a one-cycle completion pulse.

The unit holds one reservation, made of a valid bit and an address granule. A reserved read sets the reservation. Every well-formed conditional store consumes it, whether the store succeeds or fails. A snooped write from another agent that lands in the reserved granule also clears it. A conditional store reaches memory only while its address falls in a live reservation. It returns a status code rather than data. The acquire and release ordering bits of the instruction are carried on every memory request as sideband flags. Caches, coherence and forward-progress rules belong to the surrounding system.

Top module: `lrsc_unit`

## Requirements
- R1: An instruction is legal only when bits 6:0 equal 0x2F and bits 14:12 equal 2 (32-bit) or 3 (64-bit). Within that, bits 31:27 equal to 0x02 select a reserved load, but only when bits 24:20 are zero. Bits 31:27 equal to 0x03 select a conditional store. Every other word completes with `done_illegal` high, `done_rd` zero and no memory request. `done_dst` always returns bits 11:7.
- R2: The memory address is `in_rs1` itself, with no offset added.
- R3: A 64-bit reserved load returns the full response word. A 32-bit one returns bits 31:0 of the response, sign-extended to 64 bits, and ignores bits 63:32 of the response.
- R4: A conditional store whose address lies in the reserved granule (2**GRAN_LG bytes, 8 by default) issues one write and returns 0. The write carries `in_rs2` for the 64-bit form, or `in_rs2[31:0]` with `mem_req_dword` low for the 32-bit form. A 32-bit write leaves the other half of the doubleword unchanged.
- R5: A conditional store with no matching reservation issues no memory request and returns 1.
- R6: Every legal, aligned conditional store clears the reservation, so a second conditional store fails.
- R7: When `snoop_valid` is high and `snoop_addr` is in the reserved granule, the reservation is cleared. A snoop to another granule leaves it intact.
- R8: `mem_req_acq` carries instruction bit 26 and `mem_req_rel` carries bit 25 for the whole of each request.
- R9: A legal access whose address is not a multiple of its size completes with `done_misaligned` high, `done_rd` zero and no memory request.
- R10: Once raised, a memory request holds its address, data and flags steady until `mem_req_ready`. Only one operation is in flight, and `in_ready` is low from acceptance until the completion cycle has ended. After reset `in_ready` is high and no request is raised.
- R11: `done_valid` is high for exactly one cycle per accepted instruction, and never at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle; the offered instruction is taken on this edge |
| in_insn | input | 32 | Instruction word |
| in_rs1 | input | XLEN | Base address operand |
| in_rs2 | input | XLEN | Store data operand |
| done_valid | output | 1 | Completion pulse |
| done_rd | output | XLEN | Loaded value or conditional-store status |
| done_dst | output | 5 | Destination register index |
| done_misaligned | output | 1 | Alignment fault |
| done_illegal | output | 1 | Instruction not handled |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_dword | output | 1 | 1 for 64-bit access, 0 for 32-bit |
| mem_req_acq | output | 1 | Acquire ordering flag |
| mem_req_rel | output | 1 | Release ordering flag |
| mem_req_addr | output | ADDR_W | Byte address |
| mem_req_wdata | output | XLEN | Write data, right-aligned |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | XLEN | Read data, right-aligned |
| snoop_valid | input | 1 | Write by another agent observed |
| snoop_addr | input | ADDR_W | Address of that write |

## Verification
Reserved loads are tried on a word whose sign bit is set and on one whose sign bit is clear. The response's upper half is filled with a junk pattern, which separates true sign extension from pass-through and from zero fill. Conditional stores are driven after a fresh load, straight after an earlier store, after a snoop inside and outside the granule, and at an address outside the granule. Each outcome is confirmed by counting writes at the memory port and by reading the location back. Misaligned addresses of both sizes and several malformed words (wrong function, wrong width, wrong opcode, nonzero source field on a load) must finish without any memory traffic. The memory model stalls its ready signal on a repeating pattern so that request holding is exercised.

// File: rtl/lrsc_pkg.sv
`timescale 1ns/1ps
package lrsc_pkg;
   localparam logic [6:0] OPC_ATOMIC    = 7'h2F;
   localparam logic [4:0] FN_RESV_LOAD  = 5'h02;
   localparam logic [4:0] FN_COND_STORE = 5'h03;
   localparam logic [2:0] SZ_WORD       = 3'd2;
   localparam logic [2:0] SZ_DWORD      = 3'd3;

   typedef enum logic [1:0] {OPK_LOAD, OPK_STORE, OPK_BAD} opk_e;

   typedef struct packed {
      opk_e       kind;
      logic       dword;
      logic       acq;
      logic       rel;
      logic [4:0] dst;
   } dec_t;

   typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_DONE} st_e;
endpackage

// File: rtl/lrsc_decode.sv
`timescale 1ns/1ps
module lrsc_decode
   import lrsc_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic [31:0]       insn,
   input  logic [ADDR_W-1:0] addr,
   output dec_t              dec,
   output logic              misaligned
);
   logic [4:0] fn;
   logic [2:0] sz;
   logic       unused_src_idx;

   assign fn             = insn[31:27];
   assign sz             = insn[14:12];
   assign unused_src_idx = ^insn[19:15];

   always_comb begin
      dec.kind  = OPK_BAD;
      dec.dword = (sz == SZ_DWORD);
      dec.acq   = insn[26];
      dec.rel   = insn[25];
      dec.dst   = insn[11:7];
      if (insn[6:0] == OPC_ATOMIC && (sz == SZ_WORD || sz == SZ_DWORD)) begin
         if (fn == FN_RESV_LOAD && insn[24:20] == 5'd0)
            dec.kind = OPK_LOAD;
         else if (fn == FN_COND_STORE)
            dec.kind = OPK_STORE;
      end
   end

   assign misaligned = dec.dword ? (|addr[2:0]) : (|addr[1:0]);
endmodule

// File: rtl/lrsc_resv.sv
`timescale 1ns/1ps
module lrsc_resv #(
   parameter int ADDR_W   = 64,
   parameter int GRAN_LG  = 3,
   parameter bit SNOOP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set,
   input  logic [ADDR_W-1:0] set_addr,
   input  logic              clear,
   input  logic              snoop_valid,
   input  logic [ADDR_W-1:0] snoop_addr,
   input  logic [ADDR_W-1:0] chk_addr,
   output logic              hit
);
   localparam int TAG_W = ADDR_W - GRAN_LG;

   logic             valid_q;
   logic [TAG_W-1:0] tag_q;
   logic             snoop_hit;
   logic             unused_low;

   assign unused_low = ^{set_addr[GRAN_LG-1:0], chk_addr[GRAN_LG-1:0], snoop_addr[GRAN_LG-1:0]};
   assign hit        = valid_q && (chk_addr[ADDR_W-1:GRAN_LG] == tag_q);

   generate
      if (SNOOP_EN) begin : g_snoop
         assign snoop_hit = snoop_valid && valid_q && (snoop_addr[ADDR_W-1:GRAN_LG] == tag_q);

         assert_snoop_kill_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (snoop_valid && valid_q && snoop_addr[ADDR_W-1:GRAN_LG] == tag_q && !set) |=> !valid_q);
      end else begin : g_nosnoop
         logic unused_snoop;
         assign unused_snoop = ^{snoop_valid, snoop_addr};
         assign snoop_hit    = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         tag_q   <= '0;
      end else if (set) begin
         valid_q <= 1'b1;
         tag_q   <= set_addr[ADDR_W-1:GRAN_LG];
      end else if (clear || snoop_hit) begin
         valid_q <= 1'b0;
      end
   end

   assert_sc_consumes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !set) |=> !valid_q);

   assert_set_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> valid_q);
endmodule

// File: rtl/lrsc_seq.sv
`timescale 1ns/1ps
module lrsc_seq
   import lrsc_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter int ADDR_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  dec_t              dec,
   input  logic              misaligned,
   input  logic              resv_hit,
   input  logic [ADDR_W-1:0] addr,
   input  logic [XLEN-1:0]   wdata,
   output logic              sc_clear,
   output logic              resv_set,
   output logic              done_valid,
   output logic [XLEN-1:0]   done_rd,
   output logic [4:0]        done_dst,
   output logic              done_misaligned,
   output logic              done_illegal,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic              mem_req_dword,
   output logic              mem_req_acq,
   output logic              mem_req_rel,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [XLEN-1:0]   mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [XLEN-1:0]   mem_rsp_rdata
);
   localparam int HI_W = XLEN - 32;

   st_e state;
   logic accept;

   assign in_ready      = (state == ST_IDLE);
   assign accept        = in_ready && in_valid;
   assign mem_req_valid = (state == ST_REQ);
   assign done_valid    = (state == ST_DONE);
   assign sc_clear      = accept && dec.kind == OPK_STORE && !misaligned;
   assign resv_set      = mem_req_valid && mem_req_ready && !mem_req_write;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state           <= ST_IDLE;
         done_rd         <= '0;
         done_dst        <= '0;
         done_misaligned <= 1'b0;
         done_illegal    <= 1'b0;
         mem_req_write   <= 1'b0;
         mem_req_dword   <= 1'b0;
         mem_req_acq     <= 1'b0;
         mem_req_rel     <= 1'b0;
         mem_req_addr    <= '0;
         mem_req_wdata   <= '0;
      end else begin
         case (state)
            ST_IDLE: if (in_valid) begin
               done_rd         <= '0;
               done_dst        <= dec.dst;
               done_misaligned <= 1'b0;
               done_illegal    <= 1'b0;
               mem_req_addr    <= addr;
               mem_req_dword   <= dec.dword;
               mem_req_acq     <= dec.acq;
               mem_req_rel     <= dec.rel;
               mem_req_write   <= (dec.kind == OPK_STORE);
               mem_req_wdata   <= dec.dword ? wdata : {{HI_W{1'b0}}, wdata[31:0]};
               if (dec.kind == OPK_BAD) begin
                  done_illegal <= 1'b1;
                  state        <= ST_DONE;
               end else if (misaligned) begin
                  done_misaligned <= 1'b1;
                  state           <= ST_DONE;
               end else if (dec.kind == OPK_STORE && !resv_hit) begin
                  done_rd <= XLEN'(1);
                  state   <= ST_DONE;
               end else begin
                  state <= ST_REQ;
               end
            end
            ST_REQ: if (mem_req_ready) state <= mem_req_write ? ST_DONE : ST_WAIT;
            ST_WAIT: if (mem_rsp_valid) begin
               done_rd <= mem_req_dword ? mem_rsp_rdata
                                        : {{HI_W{mem_rsp_rdata[31]}}, mem_rsp_rdata[31:0]};
               state   <= ST_DONE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assert_req_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
         && $stable(mem_req_wdata) && $stable(mem_req_write) && $stable(mem_req_acq)
         && $stable(mem_req_rel) && $stable(mem_req_dword)));

   assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !in_ready);

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid);

   assert_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (mem_req_dword ? (mem_req_addr[2:0] == 3'd0) : (mem_req_addr[1:0] == 2'd0)));

   assert_fault_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> !(done_illegal && done_misaligned));

   assert_word_sext_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && mem_rsp_valid && !mem_req_dword)
      |=> (done_rd[XLEN-1:32] == {HI_W{$past(mem_rsp_rdata[31])}}));
endmodule

// File: rtl/lrsc_unit.sv
`timescale 1ns/1ps
module lrsc_unit
   import lrsc_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter int ADDR_W   = 64,
   parameter int GRAN_LG  = 3,
   parameter bit SNOOP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [31:0]       in_insn,
   input  logic [XLEN-1:0]   in_rs1,
   input  logic [XLEN-1:0]   in_rs2,
   output logic              done_valid,
   output logic [XLEN-1:0]   done_rd,
   output logic [4:0]        done_dst,
   output logic              done_misaligned,
   output logic              done_illegal,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic              mem_req_dword,
   output logic              mem_req_acq,
   output logic              mem_req_rel,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [XLEN-1:0]   mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [XLEN-1:0]   mem_rsp_rdata,
   input  logic              snoop_valid,
   input  logic [ADDR_W-1:0] snoop_addr
);
   generate
      if (XLEN != 64) begin : g_bad_xlen
         $error("lrsc_unit: XLEN must be 64");
      end
      if (ADDR_W > XLEN || ADDR_W <= GRAN_LG) begin : g_bad_addr
         $error("lrsc_unit: ADDR_W must lie in (GRAN_LG, XLEN]");
      end
      if (GRAN_LG < 3) begin : g_bad_gran
         $error("lrsc_unit: granule must cover a doubleword");
      end
      if (ADDR_W < XLEN) begin : g_hi_addr
         logic unused_addr_hi;
         assign unused_addr_hi = ^in_rs1[XLEN-1:ADDR_W];
      end
   endgenerate

   dec_t              dec;
   logic              misaligned;
   logic              resv_hit;
   logic              resv_set;
   logic              sc_clear;
   logic [ADDR_W-1:0] addr;

   assign addr = in_rs1[ADDR_W-1:0];

   lrsc_decode #(.ADDR_W(ADDR_W)) u_decode (
      .insn       (in_insn),
      .addr       (addr),
      .dec        (dec),
      .misaligned (misaligned)
   );

   lrsc_resv #(.ADDR_W(ADDR_W), .GRAN_LG(GRAN_LG), .SNOOP_EN(SNOOP_EN)) u_resv (
      .clk         (clk),
      .rst_n       (rst_n),
      .set         (resv_set),
      .set_addr    (mem_req_addr),
      .clear       (sc_clear),
      .snoop_valid (snoop_valid),
      .snoop_addr  (snoop_addr),
      .chk_addr    (addr),
      .hit         (resv_hit)
   );

   lrsc_seq #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_seq (
      .clk             (clk),
      .rst_n           (rst_n),
      .in_valid        (in_valid),
      .in_ready        (in_ready),
      .dec             (dec),
      .misaligned      (misaligned),
      .resv_hit        (resv_hit),
      .addr            (addr),
      .wdata           (in_rs2),
      .sc_clear        (sc_clear),
      .resv_set        (resv_set),
      .done_valid      (done_valid),
      .done_rd         (done_rd),
      .done_dst        (done_dst),
      .done_misaligned (done_misaligned),
      .done_illegal    (done_illegal),
      .mem_req_valid   (mem_req_valid),
      .mem_req_ready   (mem_req_ready),
      .mem_req_write   (mem_req_write),
      .mem_req_dword   (mem_req_dword),
      .mem_req_acq     (mem_req_acq),
      .mem_req_rel     (mem_req_rel),
      .mem_req_addr    (mem_req_addr),
      .mem_req_wdata   (mem_req_wdata),
      .mem_rsp_valid   (mem_rsp_valid),
      .mem_rsp_rdata   (mem_rsp_rdata)
   );
endmodule

// File: tb/lrsc_unit_tb_top.sv
`timescale 1ns/1ps
module lrsc_unit_tb_top;
   localparam int XLEN   = 64;
   localparam int ADDR_W = 64;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              in_valid;
   logic              in_ready;
   logic [31:0]       in_insn;
   logic [XLEN-1:0]   in_rs1, in_rs2;
   logic              done_valid;
   logic [XLEN-1:0]   done_rd;
   logic [4:0]        done_dst;
   logic              done_misaligned, done_illegal;
   logic              mem_req_valid, mem_req_ready, mem_req_write, mem_req_dword;
   logic              mem_req_acq, mem_req_rel;
   logic [ADDR_W-1:0] mem_req_addr;
   logic [XLEN-1:0]   mem_req_wdata;
   logic              mem_rsp_valid;
   logic [XLEN-1:0]   mem_rsp_rdata;
   logic              snoop_valid;
   logic [ADDR_W-1:0] snoop_addr;

   always #2 clk = ~clk;

   lrsc_unit #(.XLEN(XLEN), .ADDR_W(ADDR_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_insn(in_insn), .in_rs1(in_rs1), .in_rs2(in_rs2),
      .done_valid(done_valid), .done_rd(done_rd), .done_dst(done_dst),
      .done_misaligned(done_misaligned), .done_illegal(done_illegal),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_write(mem_req_write), .mem_req_dword(mem_req_dword),
      .mem_req_acq(mem_req_acq), .mem_req_rel(mem_req_rel),
      .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
      .snoop_valid(snoop_valid), .snoop_addr(snoop_addr)
   );

   int n_chk  = 0;
   int n_fail = 0;

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   // ---------------- memory model ----------------
   logic [63:0] mem [64];
   int          wr_cnt = 0;
   int          rd_cnt = 0;
   int          stall_ctr = 0;
   bit          pend;
   logic [63:0] pend_data;
   logic [63:0] last_addr;
   bit          last_acq, last_rel;

   always @(negedge clk) begin
      if (!rst_n) begin
         mem_req_ready = 1'b0;
         mem_rsp_valid = 1'b0;
         mem_rsp_rdata = '0;
         pend          = 1'b0;
      end else begin
         mem_rsp_valid = pend;
         mem_rsp_rdata = pend ? pend_data : 64'h0;
         pend          = 1'b0;
         stall_ctr++;
         mem_req_ready = (stall_ctr % 3) != 0;
         if (mem_req_valid && mem_req_ready) begin
            last_addr = mem_req_addr;
            last_acq  = mem_req_acq;
            last_rel  = mem_req_rel;
            if (mem_req_write) begin
               wr_cnt++;
               if (mem_req_dword)     mem[mem_req_addr[8:3]]        = mem_req_wdata;
               else if (mem_req_addr[2]) mem[mem_req_addr[8:3]][63:32] = mem_req_wdata[31:0];
               else                   mem[mem_req_addr[8:3]][31:0]  = mem_req_wdata[31:0];
            end else begin
               rd_cnt++;
               pend      = 1'b1;
               pend_data = mem_req_dword ? mem[mem_req_addr[8:3]]
                         : {32'hA5A5_A5A5, mem_req_addr[2] ? mem[mem_req_addr[8:3]][63:32]
                                                           : mem[mem_req_addr[8:3]][31:0]};
            end
         end
      end
   end

   // ---------------- scoreboard ----------------
   typedef struct {
      logic [63:0] rd;
      bit          mis;
      bit          ill;
      int          nwr;
      int          nrd;
      bit          chk_req;
      logic [63:0] addr;
      bit          acq;
      bit          rel;
      string       tag;
      int          wr_base;
      int          rd_base;
   } exp_t;

   exp_t exp_q[$];
   exp_t mon_e;

   function automatic exp_t mk(logic [63:0] rd, bit mis, bit ill, int nwr, int nrd,
                               bit chk_req, logic [63:0] addr, bit acq, bit rel, string tag);
      exp_t e;
      e.rd = rd; e.mis = mis; e.ill = ill; e.nwr = nwr; e.nrd = nrd;
      e.chk_req = chk_req; e.addr = addr; e.acq = acq; e.rel = rel; e.tag = tag;
      e.wr_base = 0; e.rd_base = 0;
      return e;
   endfunction

   always @(negedge clk) begin
      if (rst_n && done_valid) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R11 unexpected completion: actual 1 expected 0");
         end else begin
            mon_e = exp_q.pop_front();
            chk({mon_e.tag, " rd"},         done_rd, mon_e.rd);
            chk({mon_e.tag, " misaligned"}, 64'(done_misaligned), 64'(mon_e.mis));
            chk({mon_e.tag, " illegal"},    64'(done_illegal), 64'(mon_e.ill));
            chk({mon_e.tag, " dst R1"},     64'(done_dst), 64'd10);
            chk({mon_e.tag, " writes"},     64'(wr_cnt - mon_e.wr_base), 64'(mon_e.nwr));
            chk({mon_e.tag, " reads"},      64'(rd_cnt - mon_e.rd_base), 64'(mon_e.nrd));
            if (mon_e.chk_req) begin
               chk({mon_e.tag, " addr R2"}, last_addr, mon_e.addr);
               chk({mon_e.tag, " acq R8"},  64'(last_acq), 64'(mon_e.acq));
               chk({mon_e.tag, " rel R8"},  64'(last_rel), 64'(mon_e.rel));
            end
         end
      end
   end

   // ---------------- driver ----------------
   function automatic logic [31:0] enc(logic [4:0] fn, bit aq, bit rl, logic [2:0] sz, logic [4:0] src2);
      return {fn, aq, rl, src2, 5'd6, sz, 5'd10, 7'h2F};
   endfunction

   task automatic issue(input logic [31:0] insn, input logic [63:0] rs1, input logic [63:0] rs2, input exp_t e);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      e.wr_base = wr_cnt;
      e.rd_base = rd_cnt;
      exp_q.push_back(e);
      in_valid = 1'b1; in_insn = insn; in_rs1 = rs1; in_rs2 = rs2;
      @(negedge clk);
      in_valid = 1'b0;
      while (exp_q.size() != 0) @(negedge clk);
   endtask

   task automatic lr(input bit dw, input logic [63:0] a, input bit aq, input bit rl,
                     input logic [63:0] exp_rd, input string tag);
      issue(enc(5'h02, aq, rl, dw ? 3'd3 : 3'd2, 5'd0), a, 64'h0BAD_0BAD_0BAD_0BAD,
            mk(exp_rd, 0, 0, 0, 1, 1, a, aq, rl, tag));
   endtask

   task automatic sc(input bit dw, input logic [63:0] a, input logic [63:0] d, input bit aq,
                     input bit rl, input logic [63:0] code, input string tag);
      issue(enc(5'h03, aq, rl, dw ? 3'd3 : 3'd2, 5'd7), a, d,
            mk(code, 0, 0, (code == 0) ? 1 : 0, 0, code == 0, a, aq, rl, tag));
   endtask

   task automatic fault(input logic [31:0] insn, input logic [63:0] a, input bit mis,
                        input bit ill, input string tag);
      issue(insn, a, 64'hFFFF_0000_FFFF_0000, mk(64'h0, mis, ill, 0, 0, 0, 64'h0, 0, 0, tag));
   endtask

   task automatic snoop(input logic [63:0] a);
      @(negedge clk);
      snoop_valid = 1'b1; snoop_addr = a;
      @(negedge clk);
      snoop_valid = 1'b0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog: actual hung expected finished");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_insn = '0; in_rs1 = '0; in_rs2 = '0;
      snoop_valid = 1'b0; snoop_addr = '0;
      for (int i = 0; i < 64; i++) mem[i] = {32'h0123_0000 | 32'(i), 32'h8000_1200 | 32'(i)};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 reset in_ready",      64'(in_ready), 64'd1);
      chk("R10 reset mem_req_valid", 64'(mem_req_valid), 64'd0);
      chk("R11 reset done_valid",    64'(done_valid), 64'd0);

      // word load, negative word, junk upper half in response
      lr(0, 64'h40, 1, 0, 64'hFFFF_FFFF_8000_1208, "R3 R2 lr.w negative");
      sc(0, 64'h40, 64'hDEAD_BEEF_0000_0055, 0, 1, 64'd0, "R4 R8 sc.w success");
      sc(0, 64'h40, 64'h0000_0000_0000_0077, 0, 0, 64'd1, "R6 R5 second sc fails");
      lr(1, 64'h40, 0, 0, 64'h0123_0008_0000_0055, "R4 lr.d upper half kept");
      lr(0, 64'h44, 0, 1, 64'h0000_0000_0123_0008, "R3 lr.w positive");
      sc(1, 64'h40, 64'hFEDC_BA98_7654_3210, 1, 1, 64'd0, "R4 sc.d same granule");
      lr(1, 64'h40, 0, 0, 64'hFEDC_BA98_7654_3210, "R4 readback");

      // snoop inside the granule kills, outside keeps
      lr(1, 64'h80, 0, 0, 64'h0123_0010_8000_1210, "R3 lr.d");
      snoop(64'h84);
      sc(1, 64'h80, 64'h2222_2222_2222_2222, 0, 0, 64'd1, "R7 snoop hit");
      lr(1, 64'h80, 0, 0, 64'h0123_0010_8000_1210, "R7 unchanged after failed sc");
      snoop(64'h100);
      sc(1, 64'h80, 64'h1111_1111_1111_1111, 0, 0, 64'd0, "R7 snoop elsewhere");
      lr(1, 64'h80, 0, 0, 64'h1111_1111_1111_1111, "R4 readback after sc");
      sc(1, 64'h88, 64'h3333_3333_3333_3333, 0, 0, 64'd1, "R5 other granule");
      lr(1, 64'h88, 0, 0, 64'h0123_0011_8000_1211, "R5 no write landed");

      // misaligned accesses
      fault(enc(5'h02, 0, 0, 3'd2, 5'd0), 64'h42, 1, 0, "R9 lr.w misaligned");
      fault(enc(5'h03, 0, 0, 3'd3, 5'd7), 64'h44, 1, 0, "R9 sc.d misaligned");

      // malformed words
      fault(enc(5'h00, 0, 0, 3'd2, 5'd7), 64'h40, 0, 1, "R1 other function");
      fault(enc(5'h02, 0, 0, 3'd0, 5'd0), 64'h40, 0, 1, "R1 bad width");
      fault(enc(5'h02, 0, 0, 3'd3, 5'd3), 64'h40, 0, 1, "R1 load with src2");
      fault(enc(5'h02, 0, 0, 3'd3, 5'd0) ^ 32'h0000_002C, 64'h40, 0, 1, "R1 wrong opcode");

      repeat (3) @(negedge clk);
      chk("R11 idle after run", 64'(done_valid), 64'd0);
      summary();
      $finish;
   end
endmodule